// File: doc/BRIEF.md
# Energy-to-Pulse Output Generator

This block turns a stream of signed real-power samples into metering pulses. Each sample comes with a one-cycle strobe and is scaled by a digital gain trim of (500 + k)/500, where k is a signed step count. The scaled value is then added to two independent energy accumulators. One accumulator drives a fast calibration pulse train. The other drives two low-rate active-low pins, which carry pulses in one of two formats: a two-pin stepper drive or a direction-steered drive for a two-way counter. A registered direction flag shows the sign of the most recent non-zero sample.

Each accumulator compares its running total with a per-pulse quantum of energy. When the total reaches the quantum in either sign, the block issues one pulse, moves the total back towards zero by one quantum and keeps the remainder, so no energy is lost between pulses. If a pulse becomes due while the previous pulse on the same output is still active, a small signed counter holds it until the output is free. Pulse widths are fixed counts of master-clock ticks and depend on the selected rate.

Top module: `energy_pulse_gen`

## Requirements
- R1: At full-scale power, the calibration output `fout_n` averages `FOUT_HZ` pulses per second. After N samples from reset with power p and step k, followed by a quiet period, the number of pulses it has issued is floor(N·|p|·(500+k) / (FS·500·SR / FOUT_HZ)), where FS = 2^(PW-1)−1.
- R2: `rate_sel` sets the full-scale rate of the low-rate pins, in quarter-hertz. The codes are 0→1, 1→2, 2→4, 3→8 and 4→16, all in stepper format, and 5→8 and 6 or 7→64, in counter format. At 64 % of full-scale power the pulse count over a run lies within one pulse of 0.64 × the selected rate × the run time.
- R3: In stepper format, every pulse on `e1_n`/`e2_n` is low for exactly CLK_HZ/4 ticks at codes 0 to 3, and for exactly CLK_HZ/8 ticks at code 4.
- R4: In counter format, every pulse is low for exactly CLK_HZ/8 ticks at code 5, and for exactly CLK_HZ·15/1000 ticks at codes 6 and 7.
- R5: In stepper format with positive energy, pulses alternate between the two pins, and the first pulse after reset is on `e1_n`.
- R6: In stepper format, a negative pulse steps the phase backwards. From reset, negative energy starts on `e2_n` and then alternates. A negative pulse that follows a positive one lands on the same pin as that positive pulse.
- R7: In counter format, positive-energy pulses appear only on `e1_n` and negative-energy pulses appear only on `e2_n`.
- R8: `neg_n` goes low after a strobed sample with negative power. It holds its value through zero-power samples and returns high after a strobed sample with positive power.
- R9: `cal_step` (signed, −24..+24) scales the energy feeding both accumulators by (500 + cal_step)/500, which is 0.2 % per step.
- R10: The accumulator keeps the remainder after each pulse. The low-rate pulse count after N samples from reset is exactly floor(N·|p|·(500+k) / (FS·500·SR·4/q)), where q is the rate in quarter-hertz from R2.
- R11: During and after reset, all four outputs are high.
- R12: `e1_n` and `e2_n` are never low at the same time. Consecutive pulses are separated by at least one idle tick, and a pulse that becomes due while another is active is delayed, not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new power sample |
| power | input | PW | Signed real power; 2^(PW-1)−1 is full scale |
| rate_sel | input | 3 | Low-rate pin format and full-scale rate (see R2) |
| cal_step | input | 6 | Signed gain trim in 0.2 % steps |
| fout_n | output | 1 | Active-low calibration pulse train |
| e1_n | output | 1 | Active-low low-rate pulse pin 1 |
| e2_n | output | 1 | Active-low low-rate pulse pin 2 |
| neg_n | output | 1 | Low while the latest non-zero power was negative |

## Verification
Every rate code is first driven at full-scale positive power for exactly two pulse periods. This separates the pulse-width tables and the start phase of the stepper format, and shows pin steering in counter format. Full-scale negative power then shows the reversed stepper phase and the counter-format down pin. A positive-then-negative sequence shows that the stepper phase is undone. A sweep at 64 % power over the five fastest codes, plus ±4.8 % trims at the fastest code, exposes remainder loss, wrong quanta and wrong gain, because the counts are compared with exact integer arithmetic. A short run of negative, zero and positive samples shows that the direction flag holds its value through zero samples.

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int     PW      = 16,
  parameter int     AW      = 48,
  parameter int     QW      = 4,
  parameter longint CLK_HZ  = 4096000,
  parameter longint SR      = 32000,
  parameter longint FOUT_HZ = 10000,
  parameter int     FOUT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [PW-1:0] power,
  input  logic [2:0]           rate_sel,
  input  logic signed [5:0]    cal_step,
  output logic                 fout_n,
  output logic                 e1_n,
  output logic                 e2_n,
  output logic                 neg_n
);
  localparam longint FS   = (longint'(1) << (PW-1)) - 1;
  localparam longint BASE = FS * 500 * SR;
  localparam longint EQ   = BASE * 4;
  localparam logic signed [AW-1:0] FTHR = AW'(BASE / FOUT_HZ);
  localparam int W250 = int'(CLK_HZ / 4);
  localparam int W125 = int'(CLK_HZ / 8);
  localparam int W15  = int'(CLK_HZ * 15 / 1000);
  localparam int CW   = $clog2(W250 + 1);
  localparam int FCW  = $clog2(FOUT_W + 1);

  logic signed [AW-1:0] gain, inc, thr_e;
  logic signed [AW-1:0] facc, eacc, fsum, esum;
  logic f_up, f_dn, e_up, e_dn;
  logic [QW-1:0] fpend;
  logic signed [QW-1:0] epend, e_in, e_out;
  logic f_act, e_act, e_pin, ph, f_go, e_go, mech;
  logic [FCW-1:0] fcnt;
  logic [CW-1:0] ecnt, e_w;

  assign gain = AW'(500) + AW'(cal_step);
  assign inc  = AW'(power) * gain;
  assign mech = rate_sel[2] & (rate_sel[1] | rate_sel[0]);

  always_comb begin
    case (rate_sel)
      3'd0:    thr_e = AW'(EQ);
      3'd1:    thr_e = AW'(EQ / 2);
      3'd2:    thr_e = AW'(EQ / 4);
      3'd3:    thr_e = AW'(EQ / 8);
      3'd4:    thr_e = AW'(EQ / 16);
      3'd5:    thr_e = AW'(EQ / 8);
      default: thr_e = AW'(EQ / 64);
    endcase
    case (rate_sel)
      3'd0, 3'd1, 3'd2, 3'd3: e_w = CW'(W250);
      3'd4, 3'd5:             e_w = CW'(W125);
      default:                e_w = CW'(W15);
    endcase
  end

  assign fsum = facc + inc;
  assign esum = eacc + inc;
  assign f_up = fsum >= FTHR;
  assign f_dn = fsum <= -FTHR;
  assign e_up = esum >= thr_e;
  assign e_dn = esum <= -thr_e;

  assign f_go  = !f_act && (fpend != '0);
  assign e_go  = !e_act && (epend != '0);
  assign e_in  = (smp_valid && e_up) ? QW'(1) : (smp_valid && e_dn) ? {QW{1'b1}} : '0;
  assign e_out = !e_go ? '0 : epend[QW-1] ? {QW{1'b1}} : QW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      facc <= '0;
      eacc <= '0;
      fpend <= '0;
      epend <= '0;
      neg_n <= 1'b1;
    end else begin
      if (smp_valid) begin
        facc <= f_up ? fsum - FTHR : f_dn ? fsum + FTHR : fsum;
        eacc <= e_up ? esum - thr_e : e_dn ? esum + thr_e : esum;
        if (power < 0) neg_n <= 1'b0;
        else if (power != '0) neg_n <= 1'b1;
      end
      fpend <= fpend + QW'(smp_valid && (f_up || f_dn)) - QW'(f_go);
      epend <= epend + e_in - e_out;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_act <= 1'b0;
      fcnt  <= '0;
    end else if (f_go) begin
      f_act <= 1'b1;
      fcnt  <= FCW'(FOUT_W - 1);
    end else if (f_act) begin
      if (fcnt == '0) f_act <= 1'b0;
      else fcnt <= fcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_act <= 1'b0;
      ecnt  <= '0;
      e_pin <= 1'b0;
      ph    <= 1'b0;
    end else if (e_go) begin
      e_act <= 1'b1;
      ecnt  <= e_w - 1'b1;
      if (mech) e_pin <= epend[QW-1];
      else begin
        e_pin <= epend[QW-1] ? ~ph : ph;
        ph    <= ~ph;
      end
    end else if (e_act) begin
      if (ecnt == '0) e_act <= 1'b0;
      else ecnt <= ecnt - 1'b1;
    end
  end

  assign fout_n = !f_act;
  assign e1_n   = !(e_act && !e_pin);
  assign e2_n   = !(e_act && e_pin);

  // R12
  not_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n) (e1_n || e2_n));
  // R12
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(e1_n) || $fell(e2_n)) |-> $past(e1_n && e2_n));
  // R8
  neg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(neg_n) |-> $past(smp_valid && (power < 0)));
  // R8
  neg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(neg_n) |-> $past(smp_valid && (power > 0)));
  // R10
  facc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (facc < FTHR) && (facc > -FTHR));
endmodule

// File: tb/tb_energy_pulse_gen.sv
module tb_energy_pulse_gen;
  localparam longint FSB = 32767;
  localparam longint SRB = 256;
  localparam longint FTHRB = FSB * 500 * SRB / 64;

  logic clk = 1'b0, rst_n = 1'b0, sv = 1'b0;
  logic signed [15:0] pw = '0;
  logic [2:0] rs = '0;
  logic signed [5:0] cs = '0;
  logic fout_n, e1_n, e2_n, neg_n;

  int nchk = 0, nerr = 0;
  int ne1 = 0, ne2 = 0, nf = 0, nseq = 0, elow = 0, wexp = 0, wbad = 0, wseen = 0, both = 0;
  int seq [0:63];
  logic pe1 = 1'b1, pe2 = 1'b1, pf = 1'b1;

  always #10 clk = ~clk;

  energy_pulse_gen #(.PW(16), .AW(40), .QW(4), .CLK_HZ(2048), .SR(256),
                     .FOUT_HZ(64), .FOUT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(sv), .power(pw), .rate_sel(rs),
    .cal_step(cs), .fout_n(fout_n), .e1_n(e1_n), .e2_n(e2_n), .neg_n(neg_n));

  always @(negedge clk) begin
    if (rst_n) begin
      if (pe1 && !e1_n) begin if (nseq < 64) seq[nseq] = 0; nseq++; ne1++; end
      if (pe2 && !e2_n) begin if (nseq < 64) seq[nseq] = 1; nseq++; ne2++; end
      if (pf && !fout_n) nf++;
      if (!e1_n && !e2_n) both++;
      if (!e1_n || !e2_n) elow++;
      else if (elow != 0) begin
        if (elow != wexp) wbad++;
        wseen++;
        elow = 0;
      end
    end
    pe1 = e1_n; pe2 = e2_n; pf = fout_n;
  end

  function automatic longint qof(input int s);
    case (s)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      4: return 16; 5: return 8; default: return 64;
    endcase
  endfunction

  function automatic int wof(input int s);
    if (s <= 3) return 512;
    if (s <= 5) return 256;
    return 30;
  endfunction

  function automatic longint expect_n(input longint n, input longint p, input longint k, input longint thr);
    longint a;
    a = (p < 0) ? -p : p;
    return (n * a * (500 + k)) / thr;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic near(input string tag, input longint act, input real exp);
    real d;
    nchk++;
    d = real'(act) - exp;
    if (d > 1.0 || d < -1.0) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%f", tag, act, exp);
    end
  endtask

  task automatic clear();
    ne1 = 0; ne2 = 0; nf = 0; nseq = 0; wbad = 0; wseen = 0; elow = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; sv = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clear();
  endtask

  task automatic drive(input int p, input int s, input int k, input int n);
    pw = 16'(p); rs = 3'(s); cs = 6'(k);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sv = 1'b1;
      @(negedge clk) sv = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (1200) @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 e1_n in reset", e1_n, 1);
    chk("R11 e2_n in reset", e2_n, 1);
    chk("R11 fout_n in reset", fout_n, 1);
    chk("R11 neg_n in reset", neg_n, 1);

    // R3 R5: stepper widths and start phase at full scale, two periods each
    for (int s = 0; s <= 4; s++) begin
      do_reset();
      wexp = wof(s);
      drive(32767, s, 0, int'(2 * 1024 / qof(s)));
      drain();
      chk($sformatf("R5 sel%0d e1 count", s), ne1, 1);
      chk($sformatf("R5 sel%0d e2 count", s), ne2, 1);
      chk($sformatf("R5 sel%0d first pin", s), seq[0], 0);
      chk($sformatf("R3 sel%0d bad widths", s), wbad, 0);
      chk($sformatf("R3 sel%0d widths seen", s), wseen, 2);
      chk($sformatf("R1 sel%0d fout count", s), nf,
          expect_n(2 * 1024 / qof(s), 32767, 0, FTHRB));
    end

    // R4 R7: counter format, both signs
    for (int s = 5; s <= 6; s++) begin
      do_reset();
      wexp = wof(s);
      drive(32767, s, 0, int'(2 * 1024 / qof(s)));
      drain();
      chk($sformatf("R7 sel%0d pos e1", s), ne1, 2);
      chk($sformatf("R7 sel%0d pos e2 silent", s), ne2, 0);
      chk($sformatf("R4 sel%0d bad widths", s), wbad, 0);
      chk($sformatf("R4 sel%0d widths seen", s), wseen, 2);
      do_reset();
      drive(-32767, s, 0, int'(2 * 1024 / qof(s)));
      drain();
      chk($sformatf("R7 sel%0d neg e2", s), ne2, 2);
      chk($sformatf("R7 sel%0d neg e1 silent", s), ne1, 0);
    end

    // R2 R10 R1: 64 percent sweep
    for (int s = 2; s <= 6; s++) begin
      longint thr;
      do_reset();
      wexp = wof(s);
      thr = FSB * 500 * SRB * 4 / qof(s);
      drive(20971, s, 0, 1024);
      drain();
      chk($sformatf("R10 sel%0d exact count", s), ne1 + ne2, expect_n(1024, 20971, 0, thr));
      near($sformatf("R2 sel%0d rate 64pct", s), ne1 + ne2, 0.64 * real'(qof(s)) / 4.0 * 4.0);
      chk($sformatf("R1 sel%0d fout 64pct", s), nf, expect_n(1024, 20971, 0, FTHRB));
      chk($sformatf("R12 sel%0d no bad widths", s), wbad, 0);
    end

    // R6: negative stepper from reset
    do_reset();
    wexp = wof(4);
    drive(-32767, 4, 0, 128);
    drain();
    chk("R6 neg first pin e2", seq[0], 1);
    chk("R6 neg second pin e1", seq[1], 0);
    // R6: positive then negative undo
    do_reset();
    drive(32767, 4, 0, 64);
    drive(-32767, 4, 0, 64);
    drain();
    chk("R6 undo count", nseq, 2);
    chk("R6 undo first pin", seq[0], 0);
    chk("R6 undo second pin", seq[1], 0);

    // R9: gain trim both signs
    for (int k = -24; k <= 24; k += 48) begin
      do_reset();
      wexp = wof(6);
      drive(20971, 6, k, 1024);
      drain();
      chk($sformatf("R9 cal%0d e count", k), ne1 + ne2,
          expect_n(1024, 20971, k, FSB * 500 * SRB * 4 / 64));
      chk($sformatf("R9 cal%0d fout count", k), nf, expect_n(1024, 20971, k, FTHRB));
    end

    // R8: direction flag
    do_reset();
    drive(-100, 6, 0, 1);
    chk("R8 low after negative", neg_n, 0);
    drive(0, 6, 0, 3);
    chk("R8 held through zero", neg_n, 0);
    drive(100, 6, 0, 1);
    chk("R8 high after positive", neg_n, 1);

    chk("R12 never both low", both, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule